// File: doc/BRIEF.md
# Criticality-Based Instruction Fill Steering

This block decides where an instruction-cache line fill is placed. The instruction cache is a direct-mapped main array plus a small penalty buffer of 16 entries. When a fill arrives, the block takes the occupancy of a downstream pipeline queue: either the dispatch queue or the instruction window, chosen by a configuration input. A fill that arrives while the queue is nearly empty is critical, because the pipeline is waiting for it, and it is written into the main array. A fill that arrives while the queue is well stocked is non-critical and goes to the penalty buffer. This keeps the lines in the main array that the pipeline is most likely to stall on.

Two steering policies are available. The threshold policy compares the sampled occupancy with a configured limit. The history policy keeps, in each main-array line, the occupancy seen when that line was filled. A new fill replaces that line only if the new miss is strictly more critical than the stored one. The buffer is fully associative with least-recently-used replacement by default, or direct mapped when a parameter selects it. The cache holds instructions only, so an evicted line is dropped and never written back. Tag lookups are combinational, so the cache pipeline sees hits in the same cycle as the request.

Top module: `fill_steer_top`

## Requirements
- R1: After reset, no line is valid in either store: main_hit_o and buf_hit_o stay low for every lookup, and steer_valid_o is low.
- R2: A lookup with lookup_valid_i high sets main_hit_o when the main-array line at set lookup_line_i[5:0] is valid and holds the same upper line-address bits. buf_hit_o is set likewise for a valid buffer entry holding the whole line address.
- R3: occ_src_i = 0 selects disp_occ_i as the sampled occupancy, and occ_src_i = 1 selects win_occ_i.
- R4: With policy_i = 0 (threshold), a fill is steered to the main array when the sampled occupancy is strictly below thresh_i. Otherwise it goes to the buffer, including when the occupancy equals thresh_i.
- R5: With policy_i = 1 (history), a fill whose main-array set holds no valid line goes to the main array.
- R6: With policy_i = 1, a fill whose set holds a valid line replaces that line only if the sampled occupancy is strictly below the line's stored occupancy. Otherwise, including a tie, it goes to the buffer and the existing main line keeps hitting.
- R7: Every fill written to the main array stores its sampled occupancy as that line's history, under either policy.
- R8: steer_valid_o is high exactly in the cycle after a cycle with fill_valid_i high. In that cycle, steer_main_o is 1 if the fill went to the main array and 0 if it went to the buffer.
- R9: In the fully associative buffer, a fill replaces the least recently used entry. Entries never written count as older than any written entry. A lookup that hits the buffer makes that entry the most recent.
- R10: In the direct-mapped buffer variant, a fill goes to entry fill_line_i[3:0] and displaces whatever that entry held.
- R11: A line displaced from the main array is dropped. It hits neither store afterwards.
- R12: When a buffer lookup hit and a buffer fill occur in the same cycle, the recency update for the hit is applied first. The line just looked up is therefore not chosen as the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | Steering policy: 0 threshold, 1 history |
| occ_src_i | input | 1 | Occupancy source: 0 dispatch queue, 1 instruction window |
| thresh_i | input | OCC_W | Occupancy limit for the threshold policy |
| disp_occ_i | input | OCC_W | Valid entries in the dispatch queue |
| win_occ_i | input | OCC_W | Valid entries in the instruction window |
| lookup_valid_i | input | 1 | Lookup request this cycle |
| lookup_line_i | input | LINE_W | Line address to look up |
| main_hit_o | output | 1 | Lookup hits the main array |
| buf_hit_o | output | 1 | Lookup hits the penalty buffer |
| fill_valid_i | input | 1 | A fill line arrives this cycle |
| fill_line_i | input | LINE_W | Line address of the fill |
| steer_valid_o | output | 1 | A placement decision is reported |
| steer_main_o | output | 1 | Reported fill went to the main array (1) or the buffer (0) |

## Verification
The case that needs the most care is a buffer lookup hit and a buffer fill in the same clock. Both change the recency order, and the fill's victim choice depends on which change is applied first. The bench first fills the buffer so that every entry is valid and the order is known. It then looks up the current oldest line and, in the same cycle, fills a new line into the buffer. The looked-up line must still hit afterwards, and the next-oldest line must be the one evicted. The bench also places a threshold-policy fill just before a history-policy fill to the same set, which checks that the stored occupancy is carried across a change of policy.

// File: rtl/fill_steer_pkg.sv
package fill_steer_pkg;
  typedef enum logic {
    POL_THRESH  = 1'b0,
    POL_HISTORY = 1'b1
  } policy_e;

  typedef enum logic {
    SRC_DISPATCH = 1'b0,
    SRC_WINDOW   = 1'b1
  } occ_src_e;
endpackage

// File: rtl/fill_classifier.sv
module fill_classifier
  import fill_steer_pkg::*;
#(
  parameter int OCC_W = 7
) (
  input  policy_e          policy_i,
  input  occ_src_e         src_i,
  input  logic [OCC_W-1:0] thresh_i,
  input  logic [OCC_W-1:0] disp_occ_i,
  input  logic [OCC_W-1:0] win_occ_i,
  input  logic             vic_valid_i,
  input  logic [OCC_W-1:0] vic_hist_i,
  output logic [OCC_W-1:0] occ_o,
  output logic             to_main_o
);
  logic crit_thresh, crit_hist;

  assign occ_o       = (src_i == SRC_WINDOW) ? win_occ_i : disp_occ_i;
  assign crit_thresh = occ_o < thresh_i;
  // empty set always takes the fill; ties keep the resident line
  assign crit_hist   = !vic_valid_i || (occ_o < vic_hist_i);
  assign to_main_o   = (policy_i == POL_HISTORY) ? crit_hist : crit_thresh;
endmodule

// File: rtl/main_tag_store.sv
module main_tag_store #(
  parameter int LINE_W = 27,
  parameter int SETS   = 64,
  parameter int OCC_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] rd_line_i,
  output logic              hit_o,
  input  logic [LINE_W-1:0] wr_line_i,
  output logic              vic_valid_o,
  output logic [OCC_W-1:0]  vic_hist_o,
  input  logic              wr_en_i,
  input  logic [OCC_W-1:0]  wr_hist_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - IDX_W;

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [OCC_W-1:0] hist_q [SETS];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = rd_line_i[IDX_W-1:0];
  assign rd_tag = rd_line_i[LINE_W-1:IDX_W];
  assign wr_idx = wr_line_i[IDX_W-1:0];
  assign wr_tag = wr_line_i[LINE_W-1:IDX_W];

  assign hit_o       = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign vic_valid_o = valid_q[wr_idx];
  assign vic_hist_o  = hist_q[wr_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx]  <= wr_tag;
      hist_q[wr_idx] <= wr_hist_i;
    end
  end
endmodule

// File: rtl/penalty_buffer.sv
module penalty_buffer #(
  parameter int LINE_W      = 27,
  parameter int ENTRIES     = 16,
  parameter bit FULLY_ASSOC = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [LINE_W-1:0] lookup_line_i,
  output logic              hit_o,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [LINE_W-1:0]  line_q [ENTRIES];

  generate
    if (FULLY_ASSOC) begin : g_fa
      // age 0 = most recent; ages stay a permutation of 0..ENTRIES-1
      logic [IW-1:0]      age_q   [ENTRIES];
      logic [IW-1:0]      age_mid [ENTRIES];
      logic [IW-1:0]      age_nxt [ENTRIES];
      logic [ENTRIES-1:0] hit_vec;
      logic [IW-1:0]      hit_idx, vic_idx;
      logic               touch_hit;

      always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
          hit_vec[i] = valid_q[i] && (line_q[i] == lookup_line_i);
          if (hit_vec[i]) hit_idx = IW'(i);
        end
      end

      assign hit_o     = |hit_vec;
      assign touch_hit = lookup_valid_i && hit_o;

      // hit refresh first, then victim pick and fill refresh on top
      always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
          age_mid[i] = age_q[i];
          if (touch_hit) begin
            if (IW'(i) == hit_idx)              age_mid[i] = '0;
            else if (age_q[i] < age_q[hit_idx]) age_mid[i] = age_q[i] + 1'b1;
          end
        end
        vic_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
          if (age_mid[i] == IW'(ENTRIES - 1)) vic_idx = IW'(i);
        end
        for (int i = 0; i < ENTRIES; i++) begin
          age_nxt[i] = age_mid[i];
          if (fill_i) begin
            if (IW'(i) == vic_idx)                  age_nxt[i] = '0;
            else if (age_mid[i] < age_mid[vic_idx]) age_nxt[i] = age_mid[i] + 1'b1;
          end
        end
      end

      // unwritten entries start oldest, entry 0 first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_q <= '0;
          for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(ENTRIES - 1 - i);
        end else begin
          for (int i = 0; i < ENTRIES; i++) age_q[i] <= age_nxt[i];
          if (fill_i) valid_q[vic_idx] <= 1'b1;
        end
      end

      always_ff @(posedge clk_i) begin
        if (fill_i) line_q[vic_idx] <= fill_line_i;
      end
    end else begin : g_dm
      logic [IW-1:0] rd_idx, wr_idx;
      logic          unused_lookup;

      assign rd_idx        = lookup_line_i[IW-1:0];
      assign wr_idx        = fill_line_i[IW-1:0];
      assign hit_o         = valid_q[rd_idx] && (line_q[rd_idx] == lookup_line_i);
      assign unused_lookup = lookup_valid_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     valid_q <= '0;
        else if (fill_i) valid_q[wr_idx] <= 1'b1;
      end

      always_ff @(posedge clk_i) begin
        if (fill_i) line_q[wr_idx] <= fill_line_i;
      end
    end
  endgenerate
endmodule

// File: rtl/fill_steer_top.sv
module fill_steer_top
  import fill_steer_pkg::*;
#(
  parameter int LINE_W          = 27,
  parameter int MAIN_SETS       = 64,
  parameter int BUF_ENTRIES     = 16,
  parameter bit BUF_FULLY_ASSOC = 1'b1,
  parameter int OCC_W           = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              policy_i,
  input  logic              occ_src_i,
  input  logic [OCC_W-1:0]  thresh_i,
  input  logic [OCC_W-1:0]  disp_occ_i,
  input  logic [OCC_W-1:0]  win_occ_i,
  input  logic              lookup_valid_i,
  input  logic [LINE_W-1:0] lookup_line_i,
  output logic              main_hit_o,
  output logic              buf_hit_o,
  input  logic              fill_valid_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              steer_valid_o,
  output logic              steer_main_o
);
  logic             main_hit_raw, buf_hit_raw;
  logic             vic_valid;
  logic [OCC_W-1:0] vic_hist;
  logic [OCC_W-1:0] occ_sel;
  logic             to_main;
  logic             main_wr, buf_wr;
  logic             steer_valid_q, steer_main_q;

  fill_classifier #(.OCC_W(OCC_W)) u_cls (
    .policy_i    (policy_e'(policy_i)),
    .src_i       (occ_src_e'(occ_src_i)),
    .thresh_i    (thresh_i),
    .disp_occ_i  (disp_occ_i),
    .win_occ_i   (win_occ_i),
    .vic_valid_i (vic_valid),
    .vic_hist_i  (vic_hist),
    .occ_o       (occ_sel),
    .to_main_o   (to_main)
  );

  assign main_wr = fill_valid_i && to_main;
  assign buf_wr  = fill_valid_i && !to_main;

  main_tag_store #(.LINE_W(LINE_W), .SETS(MAIN_SETS), .OCC_W(OCC_W)) u_main (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_line_i   (lookup_line_i),
    .hit_o       (main_hit_raw),
    .wr_line_i   (fill_line_i),
    .vic_valid_o (vic_valid),
    .vic_hist_o  (vic_hist),
    .wr_en_i     (main_wr),
    .wr_hist_i   (occ_sel)
  );

  penalty_buffer #(
    .LINE_W(LINE_W), .ENTRIES(BUF_ENTRIES), .FULLY_ASSOC(BUF_FULLY_ASSOC)
  ) u_buf (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lookup_valid_i (lookup_valid_i),
    .lookup_line_i  (lookup_line_i),
    .hit_o          (buf_hit_raw),
    .fill_i         (buf_wr),
    .fill_line_i    (fill_line_i)
  );

  assign main_hit_o = lookup_valid_i && main_hit_raw;
  assign buf_hit_o  = lookup_valid_i && buf_hit_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_valid_q <= 1'b0;
      steer_main_q  <= 1'b0;
    end else begin
      steer_valid_q <= fill_valid_i;
      steer_main_q  <= main_wr;
    end
  end

  assign steer_valid_o = steer_valid_q;
  assign steer_main_o  = steer_main_q;
endmodule

// File: rtl/fill_steer_checker.sv
module fill_steer_checker #(
  parameter int LINE_W = 27,
  parameter int OCC_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              policy_i,
  input logic              occ_src_i,
  input logic [OCC_W-1:0]  thresh_i,
  input logic [OCC_W-1:0]  disp_occ_i,
  input logic [OCC_W-1:0]  win_occ_i,
  input logic              lookup_valid_i,
  input logic [LINE_W-1:0] lookup_line_i,
  input logic              main_hit_o,
  input logic              buf_hit_o,
  input logic              fill_valid_i,
  input logic [LINE_W-1:0] fill_line_i,
  input logic              steer_valid_o,
  input logic              steer_main_o,
  input logic              vic_valid_i,
  input logic [OCC_W-1:0]  vic_hist_i
);
  logic [OCC_W-1:0] occ_chk;
  assign occ_chk = occ_src_i ? win_occ_i : disp_occ_i;

  assert_steer_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> steer_valid_o);
  assert_steer_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_valid_i |=> !steer_valid_o);
  assert_thresh_main_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !policy_i && (occ_chk < thresh_i)) |=> steer_main_o);
  assert_thresh_buf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !policy_i && (occ_chk >= thresh_i)) |=> !steer_main_o);
  assert_hist_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && policy_i && !vic_valid_i) |=> steer_main_o);
  assert_hist_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && policy_i && vic_valid_i && (occ_chk >= vic_hist_i)) |=> !steer_main_o);
  assert_hist_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && policy_i && vic_valid_i && (occ_chk < vic_hist_i)) |=> steer_main_o);
  assert_main_fill_hits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steer_valid_o && steer_main_o && lookup_valid_i && (lookup_line_i == $past(fill_line_i)))
      |-> main_hit_o);
  assert_buf_fill_hits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steer_valid_o && !steer_main_o && lookup_valid_i && (lookup_line_i == $past(fill_line_i)))
      |-> buf_hit_o);
endmodule

bind fill_steer_top fill_steer_checker #(.LINE_W(LINE_W), .OCC_W(OCC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .policy_i       (policy_i),
  .occ_src_i      (occ_src_i),
  .thresh_i       (thresh_i),
  .disp_occ_i     (disp_occ_i),
  .win_occ_i      (win_occ_i),
  .lookup_valid_i (lookup_valid_i),
  .lookup_line_i  (lookup_line_i),
  .main_hit_o     (main_hit_o),
  .buf_hit_o      (buf_hit_o),
  .fill_valid_i   (fill_valid_i),
  .fill_line_i    (fill_line_i),
  .steer_valid_o  (steer_valid_o),
  .steer_main_o   (steer_main_o),
  .vic_valid_i    (vic_valid),
  .vic_hist_i     (vic_hist)
);

// File: tb/tb_fill_steer_top.sv
module tb_fill_steer_top;
  localparam int LINE_W = 27;
  localparam int OCC_W  = 7;
  localparam int NV     = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              policy = 1'b0, occ_src = 1'b0;
  logic [OCC_W-1:0]  thresh = '0, disp_occ = '0, win_occ = '0;
  logic              lookup_valid = 1'b0, fill_valid = 1'b0;
  logic [LINE_W-1:0] lookup_line = '0, fill_line = '0;
  logic              main_hit, buf_hit, steer_valid, steer_main;
  logic              dm_main_hit, dm_buf_hit, dm_steer_valid, dm_steer_main;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  fill_steer_top #(.LINE_W(LINE_W), .OCC_W(OCC_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .occ_src_i(occ_src),
    .thresh_i(thresh), .disp_occ_i(disp_occ), .win_occ_i(win_occ),
    .lookup_valid_i(lookup_valid), .lookup_line_i(lookup_line),
    .main_hit_o(main_hit), .buf_hit_o(buf_hit),
    .fill_valid_i(fill_valid), .fill_line_i(fill_line),
    .steer_valid_o(steer_valid), .steer_main_o(steer_main)
  );

  fill_steer_top #(.LINE_W(LINE_W), .OCC_W(OCC_W), .BUF_FULLY_ASSOC(1'b0)) dut_dm (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .occ_src_i(occ_src),
    .thresh_i(thresh), .disp_occ_i(disp_occ), .win_occ_i(win_occ),
    .lookup_valid_i(lookup_valid), .lookup_line_i(lookup_line),
    .main_hit_o(dm_main_hit), .buf_hit_o(dm_buf_hit),
    .fill_valid_i(fill_valid), .fill_line_i(fill_line),
    .steer_valid_o(dm_steer_valid), .steer_main_o(dm_steer_main)
  );

  // policy, source, threshold, dispatch occ, window occ, tag, set, expect main
  localparam int V_POL [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam int V_SRC [NV] = '{0, 1, 1, 0, 0, 0, 0, 1, 0, 0};
  localparam int V_THR [NV] = '{10, 10, 50, 20, 0, 0, 0, 0, 0, 0};
  localparam int V_DSP [NV] = '{3, 3, 60, 20, 30, 30, 31, 99, 3, 2};
  localparam int V_WIN [NV] = '{50, 50, 49, 0, 0, 0, 0, 29, 0, 0};
  localparam int V_TAG [NV] = '{1, 1, 1, 1, 2, 3, 4, 5, 2, 6};
  localparam int V_SET [NV] = '{0, 1, 2, 3, 4, 4, 4, 4, 0, 0};
  localparam int V_EXP [NV] = '{1, 0, 1, 0, 1, 0, 0, 1, 0, 1};

  function automatic logic [LINE_W-1:0] mk(input int tag, input int set);
    return LINE_W'((tag << 6) | set);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_fill(input int pol, input int src, input int thr, input int dsp,
                         input int win, input logic [LINE_W-1:0] line);
    @(negedge clk);
    policy     = pol[0];
    occ_src    = src[0];
    thresh     = OCC_W'(thr);
    disp_occ   = OCC_W'(dsp);
    win_occ    = OCC_W'(win);
    fill_line  = line;
    fill_valid = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // checks the lookup at the current negedge, then commits it at the next edge
  task automatic probe(input string req, input logic [LINE_W-1:0] line,
                       input logic exp_main, input logic exp_buf, input bit on_dm);
    lookup_line  = line;
    lookup_valid = 1'b1;
    #1;
    if (on_dm) begin
      check({req, " main"}, dm_main_hit, exp_main);
      check({req, " buf"}, dm_buf_hit, exp_buf);
    end else begin
      check({req, " main"}, main_hit, exp_main);
      check({req, " buf"}, buf_hit, exp_buf);
    end
    @(negedge clk);
    lookup_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    check("R1 steer_valid", steer_valid, 1'b0);
    probe("R1", mk(1, 0), 1'b0, 1'b0, 1'b0);

    // R3 R4 R5 R6 R7 table walk
    for (int v = 0; v < NV; v++) begin
      do_fill(V_POL[v], V_SRC[v], V_THR[v], V_DSP[v], V_WIN[v], mk(V_TAG[v], V_SET[v]));
      check($sformatf("R8 valid v%0d", v), steer_valid, 1'b1);
      check($sformatf("R4/R6 R3 placement v%0d", v), steer_main, V_EXP[v][0]);
      probe($sformatf("R2 v%0d", v), mk(V_TAG[v], V_SET[v]), V_EXP[v][0], !V_EXP[v][0], 1'b0);
    end
    check("R8 idle", steer_valid, 1'b0);
    // R6 tie kept the earlier line in set 4 until the window-sourced win
    probe("R11 set0 old", mk(1, 0), 1'b0, 1'b0, 1'b0);
    probe("R11 set4 old", mk(2, 4), 1'b0, 1'b0, 1'b0);
    probe("R7 set4 now", mk(5, 4), 1'b1, 1'b0, 1'b0);

    // R9 LRU order in the fully associative buffer
    do_reset();
    for (int k = 0; k < 16; k++) do_fill(0, 0, 0, 5, 5, mk(100 + k, k));
    check("R9 steer buffer", steer_main, 1'b0);
    probe("R9 touch b0", mk(100, 0), 1'b0, 1'b1, 1'b0);
    do_fill(0, 0, 0, 5, 5, mk(116, 16));
    probe("R9 b1 evicted", mk(101, 1), 1'b0, 1'b0, 1'b0);
    probe("R9 b0 kept", mk(100, 0), 1'b0, 1'b1, 1'b0);
    probe("R9 b16 in", mk(116, 16), 1'b0, 1'b1, 1'b0);
    probe("R9 b2 kept", mk(102, 2), 1'b0, 1'b1, 1'b0);

    // R12: oldest is b3; touch it in the same cycle as a new buffer fill
    @(negedge clk);
    policy       = 1'b0;
    thresh       = '0;
    lookup_line  = mk(103, 3);
    lookup_valid = 1'b1;
    fill_line    = mk(117, 17);
    fill_valid   = 1'b1;
    #1;
    check("R12 same-cycle hit", buf_hit, 1'b1);
    @(negedge clk);
    lookup_valid = 1'b0;
    fill_valid   = 1'b0;
    check("R12 steer buffer", steer_main, 1'b0);
    probe("R12 b4 evicted", mk(104, 4), 1'b0, 1'b0, 1'b0);
    probe("R12 b3 kept", mk(103, 3), 1'b0, 1'b1, 1'b0);
    probe("R12 b17 in", mk(117, 17), 1'b0, 1'b1, 1'b0);

    // R10 direct-mapped buffer: index = line[3:0]
    do_reset();
    do_fill(0, 0, 0, 5, 5, mk(7, 1));
    probe("R10 first", mk(7, 1), 1'b0, 1'b1, 1'b1);
    do_fill(0, 0, 0, 5, 5, mk(8, 17));
    probe("R10 displaced", mk(7, 1), 1'b0, 1'b0, 1'b1);
    probe("R10 second", mk(8, 17), 1'b0, 1'b1, 1'b1);
    check("R8 dm steer", dm_steer_valid, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule